// File: doc/BRIEF.md
# Serial Peripheral Master with Chip-Select Spacing

This block drives a four-wire synchronous serial link as the master. Words are loaded through a small transmit queue, and each word goes out in its own frame, most significant bit first. The word received on the data-in pin during that frame is presented on a result port. All four combinations of clock idle level and sampling phase are supported. The serial clock is derived from the system clock by a programmable half-period count, so its high and low times are equal.

The chip-select pin has guaranteed spacing, counted in whole serial clock periods, in three places: before the first clock edge (lead), after the last clock edge (lag), and while it is deasserted between frames (gap). A frame starts by itself after the gap whenever the queue still holds data. When the queue runs dry and the last frame's gap has expired, the transmitter drops from active to idle and sets a sticky status bit. Software clears that bit by writing 1.

The transmit port is a valid/ready stream. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low only while the queue is full, and a producer must then hold its word until it is accepted. The received word has no back-pressure: `rx_valid` is a single-cycle strobe and `rx_data` holds its value until the next frame completes. `cpol`, `cpha` and `half_div` must only be changed while the transmitter is idle.

Top module: `spi_master_cs`

## Requirements
- R1: Every frame carries 8 bits, most significant bit first. In every mode, the bit on `mosi` is stable at each sampling edge. The sampling edge is the leading edge when `cpha`=0 and the trailing edge when `cpha`=1, where the leading edge is the one that leaves the `cpol` level.
- R2: One cycle after the last clock edge of a frame, `rx_valid` pulses for exactly one cycle, with the 8 bits sampled from `miso` on `rx_data` (first sampled bit in bit 7). `rx_valid` is never high while `cs_n` is high.
- R3: Within a frame, each high and each low level of `sclk` lasts exactly `half_div` system cycles. Outside the data phase, `sclk` sits at the `cpol` level.
- R4: From `cs_n` falling to the first `sclk` edge, at least LEAD_T serial clock periods pass.
- R5: From the last `sclk` edge of a frame to `cs_n` rising, at least LAG_T serial clock periods pass.
- R6: Between frames, `cs_n` stays high for at least GAP_T serial clock periods.
- R7: A word is accepted only on an edge where `tx_valid` and `tx_ready` are both high. `tx_ready` goes low when FIFO_DEPTH words are queued, and a word offered while it is low is not transmitted.
- R8: If the queue holds data when a gap ends, the next frame begins with `cs_n` falling exactly GAP_T periods after it rose. The idle status bit stays 0 throughout such a burst.
- R9: After reset the idle status bit (register bit 1) is 0, `cs_n` is 1 and `tx_ready` is 1. The bit becomes 1 when the gap after a frame ends with the queue empty.
- R10: A register write with data bit 1 set clears the idle bit. A write with data bit 1 clear leaves it unchanged. Register bits 31:2 and bit 0 always read 0.
- R11: When a clearing write falls in the same cycle as the set event, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| half_div | input | DIV_W | System cycles per serial clock half period (0 treated as 1) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Queue can take a word |
| tx_data | input | 8 | Transmit word |
| rx_valid | output | 1 | One-cycle strobe: received word ready |
| rx_data | output | 8 | Last received word |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Status register write data |
| reg_rdata | output | 32 | Status register contents |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with a four-entry queue, LEAD_T=1, LAG_T=2 and GAP_T=4, and uses half periods of 2 and 3 system cycles. A lag that differs from the lead, and a gap longer than both, lets a swapped or truncated counter show up as a measured spacing error. The shallow queue lets a short burst fill the queue while a frame is in flight, so the back-pressure case is reachable. The odd half period exposes any duty-cycle rounding.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int WORD_W   = 8;
  localparam int REG_W    = 32;
  localparam int IDLE_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_LAG,
    ST_GAP
  } spi_st_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/spi_cs_fifo.sv
module spi_cs_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_divider.sv
module spi_cs_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // a zero half period is promoted to one system cycle
  assign limit = (half_div == '0) ? '0 : half_div - 1'b1;
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_cs_engine.sv
module spi_cs_engine
  import spi_cs_pkg::*;
#(
  parameter int LEAD_T = 1,
  parameter int LAG_T  = 1,
  parameter int GAP_T  = 4,
  parameter int PH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_head,
  output logic              q_pop,
  output logic              run,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              idle_set
);
  localparam logic [PH_W-1:0] LEAD_LAST = PH_W'(2 * LEAD_T - 1);
  localparam logic [PH_W-1:0] LAG_LAST  = PH_W'(2 * LAG_T - 1);
  localparam logic [PH_W-1:0] GAP_LAST  = PH_W'(2 * GAP_T - 1);
  localparam logic [PH_W-1:0] XFER_LAST = PH_W'(2 * WORD_W - 1);

  spi_st_e           st;
  logic [PH_W-1:0]   ph;
  logic              sclk_q;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_next;
  logic              lead_edge, sample_now, shift_now, gap_done;

  assign run        = (st != ST_IDLE);
  assign sclk       = (st == ST_XFER) ? sclk_q : cpol;
  assign mosi       = tx_sh[WORD_W-1];
  assign rx_next    = {rx_sh[WORD_W-2:0], miso};
  assign lead_edge  = !ph[0];
  assign sample_now = lead_edge ^ cpha;
  assign shift_now  = !sample_now && (ph != '0) && (ph != XFER_LAST);
  assign gap_done   = (st == ST_GAP) && tick && (ph == GAP_LAST);
  assign q_pop      = !q_empty && ((st == ST_IDLE) || gap_done);
  assign idle_set   = gap_done && q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= '0;
      cs_n     <= 1'b1;
      sclk_q   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (q_pop) begin
        st     <= ST_LEAD;
        ph     <= '0;
        cs_n   <= 1'b0;
        sclk_q <= cpol;
        tx_sh  <= q_head;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_LEAD: if (tick) begin
            if (ph == LEAD_LAST) begin
              st <= ST_XFER;
              ph <= '0;
            end else ph <= ph + 1'b1;
          end
          ST_XFER: if (tick) begin
            sclk_q <= !sclk_q;
            if (sample_now) rx_sh <= rx_next;
            if (shift_now)  tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            if (ph == XFER_LAST) begin
              st       <= ST_LAG;
              ph       <= '0;
              rx_valid <= 1'b1;
              rx_data  <= cpha ? rx_next : rx_sh;
            end else ph <= ph + 1'b1;
          end
          ST_LAG: if (tick) begin
            if (ph == LAG_LAST) begin
              st   <= ST_GAP;
              ph   <= '0;
              cs_n <= 1'b1;
            end else ph <= ph + 1'b1;
          end
          ST_GAP: if (tick) begin
            if (ph == GAP_LAST) begin
              st <= ST_IDLE;
              ph <= '0;
            end else ph <= ph + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cs_status.sv
module spi_cs_status
  import spi_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ev,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  logic idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idle_q <= 1'b0;
    else if (set_ev)                 idle_q <= 1'b1;
    else if (wr && wdata[IDLE_BIT])  idle_q <= 1'b0;
  end

  always_comb begin
    rdata           = '0;
    rdata[IDLE_BIT] = idle_q;
  end
endmodule

// File: rtl/spi_master_cs.sv
module spi_master_cs
  import spi_cs_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  parameter int LEAD_T     = 1,
  parameter int LAG_T      = 1,
  parameter int GAP_T      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int PH_MAX = max_of4(2 * LEAD_T, 2 * LAG_T, 2 * GAP_T, 2 * WORD_W);
  localparam int PH_W   = $clog2(PH_MAX);

  logic              q_pop, q_empty, q_full, run, tick, idle_set;
  logic [WORD_W-1:0] q_head;

  assign tx_ready = !q_full;

  spi_cs_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .push_data(tx_data),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  spi_cs_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div), .tick(tick)
  );

  spi_cs_engine #(.LEAD_T(LEAD_T), .LAG_T(LAG_T), .GAP_T(GAP_T), .PH_W(PH_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .tick(tick),
    .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop), .run(run),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .rx_valid(rx_valid), .rx_data(rx_data), .idle_set(idle_set)
  );

  spi_cs_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_ev(idle_set), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata)
  );
endmodule

// File: rtl/spi_cs_chk.sv
module spi_cs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sclk,
  input logic        cpol,
  input logic        rx_valid,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        set_ev
);
  // R3: clock parked at the idle level whenever chip select is high
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cpol));

  // R2: received-word strobe lasts one cycle, only inside a frame
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r2_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);

  // R4: no clock edge right after chip select falls
  a_r4_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> $stable(sclk));

  // R5: no clock edge coincides with chip select rising
  a_r5_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $stable(sclk));

  // R10: unused bits read zero; a zero write keeps the bit
  a_r10_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:2] == '0) && !reg_rdata[0]);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !(reg_wr && reg_wdata[1])) |=> reg_rdata[1]);

  // R11: the set event wins over a simultaneous clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> reg_rdata[1]);
endmodule

bind spi_master_cs spi_cs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cpol(cpol),
  .rx_valid(rx_valid), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .set_ev(idle_set)
);

// File: tb/sim_spi_master_cs.sv
module sim_spi_master_cs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int DIV_W  = 6;
  localparam int LEAD_T = 1;
  localparam int LAG_T  = 2;
  localparam int GAP_T  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic [DIV_W-1:0] half_div = 6'd2;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic rx_valid;
  logic [7:0] rx_data;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sclk, mosi, cs_n;
  logic miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_master_cs #(.FIFO_DEPTH(DEPTH), .DIV_W(DIV_W), .LEAD_T(LEAD_T),
                  .LAG_T(LAG_T), .GAP_T(GAP_T)) u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .half_div(half_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model and pin monitor
  logic [7:0] tbytes [8];
  logic [7:0] sbytes [8];
  logic [7:0] cap [8];
  int fidx = 0, rxi = 0;
  logic [7:0] s_tx, s_rx;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  int t_fall = 0, t_edge = 0, t_rise = 0;
  bit first_edge = 0, have_rise = 0, burst_chk = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        if (have_rise) begin
          check((cyc - t_rise) >= 2*GAP_T*int'(half_div), "R6 gap", cyc - t_rise, 2*GAP_T*int'(half_div));
          if (burst_chk) begin
            check((cyc - t_rise) == 2*GAP_T*int'(half_div), "R8 auto start", cyc - t_rise, 2*GAP_T*int'(half_div));
            check(reg_rdata[1] == 1'b0, "R8 idle bit in burst", int'(reg_rdata[1]), 0);
          end
        end
        t_fall = cyc;
        first_edge = 1;
        s_rx = '0;
        s_tx = sbytes[fidx];
        if (!cpha) begin miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
      end else if (!cs_n && sclk != prev_sclk) begin
        if (first_edge) begin
          check((cyc - t_fall) >= 2*LEAD_T*int'(half_div), "R4 lead", cyc - t_fall, 2*LEAD_T*int'(half_div));
          first_edge = 0;
        end else
          check((cyc - t_edge) == int'(half_div), "R3 half period", cyc - t_edge, int'(half_div));
        t_edge = cyc;
        if (((sclk != cpol) ? 1'b1 : 1'b0) ^ cpha) s_rx = {s_rx[6:0], mosi};
        else begin miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
      end else if (!prev_cs && cs_n) begin
        check((cyc - t_edge) >= 2*LAG_T*int'(half_div), "R5 lag", cyc - t_edge, 2*LAG_T*int'(half_div));
        cap[fidx] = s_rx;
        fidx++;
        t_rise = cyc;
        have_rise = 1;
      end
      if (rx_valid) begin
        check(rx_data == sbytes[rxi], "R2 received word", int'(rx_data), int'(sbytes[rxi]));
        rxi++;
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic push(input logic [7:0] d);
    tx_valid = 1'b1;
    tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    @(negedge clk);
  endtask

  task automatic wait_idle_bit();
    int k = 0;
    while (!reg_rdata[1] && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic setup(input bit pol, input bit pha, input int hd, input bit burst);
    cpol = pol; cpha = pha; half_div = DIV_W'(hd);
    fidx = 0; rxi = 0; have_rise = 0; burst_chk = burst;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(cs_n == 1'b1, "R9 reset cs_n", int'(cs_n), 1);
    check(reg_rdata == 32'h0, "R9 reset status", int'(reg_rdata), 0);
    check(tx_ready == 1'b1, "R9 reset ready", int'(tx_ready), 1);
    check(sclk == cpol, "R3 reset clock level", int'(sclk), int'(cpol));
  endtask

  task automatic t_mode(input bit pol, input bit pha, input int hd, input logic [7:0] tb, input logic [7:0] sb);
    setup(pol, pha, hd, 0);
    tbytes[0] = tb; sbytes[0] = sb;
    push(tb);
    wait_idle_bit();
    check(fidx == 1, "R1 frame count", fidx, 1);
    check(cap[0] == tb, "R1 bits on mosi", int'(cap[0]), int'(tb));
    check(rxi == 1, "R2 strobe count", rxi, 1);
    check(sclk == pol, "R3 idle level", int'(sclk), int'(pol));
    check(reg_rdata[1] == 1'b1, "R9 idle bit set", int'(reg_rdata[1]), 1);
    reg_write(32'h0);
    check(reg_rdata[1] == 1'b1, "R10 zero write kept", int'(reg_rdata[1]), 1);
    reg_write(32'hFFFF_FFFF);
    check(reg_rdata == 32'h0, "R10 clear by one", int'(reg_rdata), 0);
  endtask

  task automatic t_burst();
    setup(1'b1, 1'b0, 3, 1);
    for (int i = 0; i < 3; i++) begin
      tbytes[i] = 8'h3C + 8'(i * 17); sbytes[i] = 8'hA1 ^ 8'(i * 5);
    end
    for (int i = 0; i < 3; i++) push(tbytes[i]);
    wait_idle_bit();
    check(fidx == 3, "R8 frames in burst", fidx, 3);
    for (int i = 0; i < 3; i++)
      check(cap[i] == tbytes[i], "R1 burst word", int'(cap[i]), int'(tbytes[i]));
    reg_write(32'h2);
  endtask

  task automatic t_full();
    setup(1'b0, 1'b1, 2, 1);
    for (int i = 0; i < 5; i++) begin
      tbytes[i] = 8'h11 * 8'(i + 1); sbytes[i] = 8'h5A + 8'(i);
    end
    for (int i = 0; i < 5; i++) push(tbytes[i]);
    check(tx_ready == 1'b0, "R7 ready low when full", int'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = 8'hEE;
    for (int i = 0; i < 3; i++) @(negedge clk);
    tx_valid = 1'b0;
    wait_idle_bit();
    check(fidx == 5, "R7 ignored push", fidx, 5);
    for (int i = 0; i < 5; i++)
      check(cap[i] == tbytes[i], "R7 accepted words", int'(cap[i]), int'(tbytes[i]));
    reg_write(32'h2);
  endtask

  task automatic t_setwins();
    int seen = 0;
    setup(1'b0, 1'b0, 2, 0);
    tbytes[0] = 8'h81; sbytes[0] = 8'h7E;
    reg_wr = 1'b1; reg_wdata = 32'h2;
    push(8'h81);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (reg_rdata[1]) seen++;
    end
    reg_wr = 1'b0; reg_wdata = '0;
    check(seen == 1, "R11 set beats clear", seen, 1);
    check(cap[0] == 8'h81, "R1 word under write", int'(cap[0]), 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode(1'b0, 1'b0, 2, 8'hA5, 8'h3C);
    t_mode(1'b0, 1'b1, 2, 8'h96, 8'hC3);
    t_mode(1'b1, 1'b0, 3, 8'h01, 8'h80);
    t_mode(1'b1, 1'b1, 3, 8'hF0, 8'h0F);
    t_burst();
    t_full();
    t_setwins();
    done = 1;
  end

  initial begin
    int k = 0;
    while (!done && k < 200000) begin @(negedge clk); k++; end
    if (!done) check(1'b0, "watchdog", k, 200000);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule